// File: doc/BRIEF.md
# Cascadable Acquisition Sample Counter

This block ends a data-acquisition run after a programmed number of converted samples. Software writes the total sample count, which is the number of scans times the scan length, with a load strobe. It then raises the acquisition enable and pulses the start strobe. From then on, every convert-done pulse takes one count. When the last sample of the total arrives, the block emits a one-cycle stop pulse, drops its in-progress status and latches a stop flag. The stop flag is cleared by a clear strobe.

The count stages are `STAGE_W` bits wide (16 by default). A total that fits in one stage runs on a single down-counter. A larger total sets the wide-mode indication and runs on two chained stages. In that case the low stage is preloaded with the low half minus one, and a low half of zero therefore becomes all ones. The high stage is preloaded with the upper half when the low half is 0 or 1, and with the upper half plus one otherwise. The low stage counts every sample and wraps from zero to all ones. Each time it steps from 1 to 0 it decrements the high stage. Once the high stage has reached zero, the next sample is the final one. With these corrections the run is exactly the programmed length for every low half.

Top module: `acq_sample_counter`

## Requirements
- R1: After reset, `done_pulse`, `in_progress`, `stop_flag` and `wide_mode` are all 0.
- R2: A load latches `total`. `wide_mode` is 1 one cycle later exactly when `total >= 2**STAGE_W`. A loaded total applies to the next accepted start and to every later start. A load made during a run does not change the run in progress.
- R3: A start is accepted only when `daq_enable` is 1, no run is in progress and the loaded total is nonzero. `in_progress` is 1 from the cycle after an accepted start, and a start that is not accepted leaves it at 0.
- R4: In narrow mode (total below `2**STAGE_W`), `done_pulse` is 1 in the cycle after the edge that takes the total-th sample, and never earlier.
- R5: In wide mode, the run ends on exactly the total-th sample for every low half, including low halves 0 and 1.
- R6: `sample_stb` has no effect while no run is in progress. Samples offered before a start do not shorten the following run.
- R7: The cycle in which `done_pulse` is 1 shows `in_progress` at 0. `done_pulse` lasts one cycle.
- R8: `stop_flag` is set together with `done_pulse` and holds until a `stop_clr` cycle. If the final sample and `stop_clr` arrive in the same cycle, the flag is set.
- R9: Lowering `daq_enable` during a run ends the run on the next edge without `done_pulse` or `stop_flag`. Later samples then produce no stop.
- R10: `status_word` bit 11 equals `in_progress`, bit 14 equals `stop_flag`, and every other bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| total | input | 2*STAGE_W | Total number of samples to acquire |
| load_stb | input | 1 | Latches `total` |
| daq_enable | input | 1 | Acquisition enable level |
| start_stb | input | 1 | Start-acquisition strobe |
| sample_stb | input | 1 | One pulse per converted sample |
| stop_clr | input | 1 | Clears the stop flag |
| done_pulse | output | 1 | One-cycle stop pulse on the final sample |
| in_progress | output | 1 | Acquisition running |
| stop_flag | output | 1 | Latched stop indication |
| wide_mode | output | 1 | Loaded total needs the two-stage cascade |
| status_word | output | 16 | Status: bit 11 running, bit 14 stopped |

## Verification
The assertions assume that no loaded total needs a high-stage preload beyond the stage width. That case arises when the upper half is all ones and the low half is 2 or more. The stimulus only loads totals below that limit. The assertions also assume that `load_stb` is low during reset. The bench therefore holds every strobe low while reset is asserted and drives all inputs on the falling edge. The bench narrows the stages to 6 bits, so every wide-mode corner, low halves 0, 1 and 2 included, runs in a few thousand cycles.

// File: rtl/acq_cnt_pkg.sv
package acq_cnt_pkg;
  localparam int STATUS_W      = 16;
  localparam int STAT_RUN_BIT  = 11;
  localparam int STAT_STOP_BIT = 14;
endpackage

// File: rtl/acq_preload.sv
// Latches a total and derives the preload values for the two stages.
module acq_preload #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_stb,
  input  logic [2*W-1:0] total,
  output logic [W-1:0]   lo_init,
  output logic [W-1:0]   hi_init,
  output logic           wide,
  output logic           zero
);
  logic [W-1:0] lo_half, hi_half;
  logic         need_wide;

  assign lo_half   = total[W-1:0];
  assign hi_half   = total[2*W-1:W];
  assign need_wide = |hi_half;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_init <= '0;
      hi_init <= '0;
      wide    <= 1'b0;
      zero    <= 1'b1;
    end else if (load_stb) begin
      wide <= need_wide;
      zero <= (total == '0);
      if (need_wide) begin
        // A low half of zero wraps to all ones here.
        lo_init <= lo_half - 1'b1;
        hi_init <= (lo_half <= W'(1)) ? hi_half : hi_half + 1'b1;
      end else begin
        lo_init <= lo_half;
        hi_init <= '0;
      end
    end
  end
endmodule

// File: rtl/acq_stage.sv
// One down-counting stage. It wraps from 0 to all ones and flags a 1->0 step.
module acq_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         hit
);
  logic [W-1:0] count;

  assign hit = dec && (count == W'(1));

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= load_val;
    else if (dec)  count <= count - 1'b1;
  end
endmodule

// File: rtl/acq_ctrl.sv
// Run control: start qualification, chaining, stop detection and flags.
module acq_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic daq_enable,
  input  logic start_stb,
  input  logic sample_stb,
  input  logic stop_clr,
  input  logic wide_cfg,
  input  logic zero_cfg,
  input  logic lo_hit,
  input  logic hi_hit,
  output logic stage_load,
  output logic lo_dec,
  output logic hi_dec,
  output logic running,
  output logic done_pulse,
  output logic stop_flag
);
  logic wide_run, armed, start_ok, done_evt;

  assign start_ok   = start_stb && daq_enable && !running && !zero_cfg;
  assign stage_load = start_ok;
  assign lo_dec     = running && sample_stb;
  assign hi_dec     = wide_run && lo_hit;
  assign done_evt   = daq_enable && running && sample_stb &&
                      (wide_run ? armed : lo_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      running    <= 1'b0;
      armed      <= 1'b0;
      wide_run   <= 1'b0;
      done_pulse <= 1'b0;
      stop_flag  <= 1'b0;
    end else begin
      done_pulse <= done_evt;
      if (done_evt)      stop_flag <= 1'b1;
      else if (stop_clr) stop_flag <= 1'b0;

      if (!daq_enable) begin
        running <= 1'b0;
        armed   <= 1'b0;
      end else if (start_ok) begin
        running  <= 1'b1;
        armed    <= 1'b0;
        wide_run <= wide_cfg;
      end else if (done_evt) begin
        running <= 1'b0;
        armed   <= 1'b0;
      end else if (hi_hit) begin
        armed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/acq_sample_counter.sv
module acq_sample_counter
  import acq_cnt_pkg::*;
#(
  parameter int STAGE_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2*STAGE_W-1:0] total,
  input  logic                 load_stb,
  input  logic                 daq_enable,
  input  logic                 start_stb,
  input  logic                 sample_stb,
  input  logic                 stop_clr,
  output logic                 done_pulse,
  output logic                 in_progress,
  output logic                 stop_flag,
  output logic                 wide_mode,
  output logic [STATUS_W-1:0]  status_word
);
  logic [STAGE_W-1:0] lo_init, hi_init;
  logic zero_cfg, stage_load, lo_dec, hi_dec, lo_hit, hi_hit;

  acq_preload #(.W(STAGE_W)) u_pre (
    .clk(clk), .rst(rst), .load_stb(load_stb), .total(total),
    .lo_init(lo_init), .hi_init(hi_init), .wide(wide_mode), .zero(zero_cfg)
  );

  acq_stage #(.W(STAGE_W)) u_lo (
    .clk(clk), .rst(rst), .load(stage_load), .load_val(lo_init),
    .dec(lo_dec), .hit(lo_hit)
  );

  acq_stage #(.W(STAGE_W)) u_hi (
    .clk(clk), .rst(rst), .load(stage_load), .load_val(hi_init),
    .dec(hi_dec), .hit(hi_hit)
  );

  acq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .daq_enable(daq_enable), .start_stb(start_stb),
    .sample_stb(sample_stb), .stop_clr(stop_clr), .wide_cfg(wide_mode),
    .zero_cfg(zero_cfg), .lo_hit(lo_hit), .hi_hit(hi_hit),
    .stage_load(stage_load), .lo_dec(lo_dec), .hi_dec(hi_dec),
    .running(in_progress), .done_pulse(done_pulse), .stop_flag(stop_flag)
  );

  always_comb begin
    status_word = '0;
    status_word[STAT_RUN_BIT]  = in_progress;
    status_word[STAT_STOP_BIT] = stop_flag;
  end
endmodule

// File: rtl/acq_sample_counter_chk.sv
module acq_sample_counter_chk #(
  parameter int STAGE_W = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic [2*STAGE_W-1:0] total,
  input logic                 load_stb,
  input logic                 daq_enable,
  input logic                 start_stb,
  input logic                 stop_clr,
  input logic                 done_pulse,
  input logic                 in_progress,
  input logic                 stop_flag,
  input logic                 wide_mode
);
  assert_wide_select_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(load_stb) && !$past(rst)) |->
      (wide_mode == ($past(total) >= (2*STAGE_W)'(1) << STAGE_W)));

  assert_start_qualified_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(in_progress) |-> $past(start_stb && daq_enable));

  assert_done_ends_run_R7: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> !in_progress);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> !done_pulse);

  assert_flag_with_done_R8: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> stop_flag);

  assert_flag_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (stop_flag && !stop_clr) |=> stop_flag);

  assert_abort_R9: assert property (@(posedge clk) disable iff (rst)
    !daq_enable |=> (!in_progress && !done_pulse));
endmodule

bind acq_sample_counter acq_sample_counter_chk #(.STAGE_W(STAGE_W)) u_chk (
  .clk(clk), .rst(rst), .total(total), .load_stb(load_stb),
  .daq_enable(daq_enable), .start_stb(start_stb), .stop_clr(stop_clr),
  .done_pulse(done_pulse), .in_progress(in_progress), .stop_flag(stop_flag),
  .wide_mode(wide_mode)
);

// File: tb/acq_sample_counter_test.sv
`timescale 1ns/1ps
module acq_sample_counter_test;
  localparam int W  = 6;
  localparam int NV = 11;
  // Vector table: total, expected wide mode, idle cycles between samples.
  localparam int VT [NV] = '{1, 2, 63, 64, 65, 66, 128, 129, 130, 200, 4033};
  localparam bit VW [NV] = '{0, 0, 0, 1, 1, 1, 1, 1, 1, 1, 1};
  localparam int VG [NV] = '{0, 2, 1, 0, 0, 1, 0, 0, 0, 1, 0};

  logic clk = 0;
  logic rst = 1;
  logic [2*W-1:0] total = '0;
  logic load_stb = 0, daq_enable = 0, start_stb = 0, sample_stb = 0, stop_clr = 0;
  logic done_pulse, in_progress, stop_flag, wide_mode;
  logic [15:0] status_word;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  acq_sample_counter #(.STAGE_W(W)) uut (
    .clk(clk), .rst(rst), .total(total), .load_stb(load_stb),
    .daq_enable(daq_enable), .start_stb(start_stb), .sample_stb(sample_stb),
    .stop_clr(stop_clr), .done_pulse(done_pulse), .in_progress(in_progress),
    .stop_flag(stop_flag), .wide_mode(wide_mode), .status_word(status_word)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input int t);
    @(negedge clk); total = t[2*W-1:0]; load_stb = 1;
    @(negedge clk); load_stb = 0;
  endtask

  task automatic start();
    daq_enable = 1; start_stb = 1;
    @(negedge clk); start_stb = 0;
  endtask

  // Feeds n samples with gap idle cycles before each; returns the first
  // sample index after which done_pulse was seen (0 = never).
  task automatic feed(input int n, input int gap, output int first);
    first = 0;
    for (int k = 1; k <= n; k++) begin
      repeat (gap) @(negedge clk);
      sample_stb = 1;
      @(negedge clk); sample_stb = 0;
      if (done_pulse && first == 0) first = k;
    end
  endtask

  task automatic clear_flag();
    stop_clr = 1; @(negedge clk); stop_clr = 0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    int first;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 / R10: reset state
    chk(!done_pulse && !in_progress && !stop_flag && !wide_mode, "R1",
        {done_pulse, in_progress, stop_flag, wide_mode}, 0);
    chk(status_word == 16'h0, "R10", status_word, 0);

    // Table-driven runs: R2 R4 R5 R7 R8
    for (int v = 0; v < NV; v++) begin
      load(VT[v]);
      chk(wide_mode == VW[v], "R2 wide select", wide_mode, VW[v]);
      start();
      chk(in_progress == 1, "R3 started", in_progress, 1);
      chk(status_word == 16'h0800, "R10 running", status_word, 16'h0800);
      feed(VT[v], VG[v], first);
      chk(first == VT[v], VW[v] ? "R5 wide length" : "R4 narrow length", first, VT[v]);
      chk(!in_progress && stop_flag, "R7 R8 after done", {in_progress, stop_flag}, 1);
      chk(status_word == 16'h4000, "R10 stopped", status_word, 16'h4000);
      @(negedge clk);
      chk(!done_pulse, "R7 single pulse", done_pulse, 0);
      chk(stop_flag, "R8 flag holds", stop_flag, 1);
      clear_flag();
      chk(!stop_flag, "R8 cleared", stop_flag, 0);
    end

    // R3: start ignored with enable low and with a zero total
    load(5);
    daq_enable = 0; start_stb = 1;
    @(negedge clk); start_stb = 0;
    chk(!in_progress, "R3 enable low", in_progress, 0);
    load(0);
    start();
    chk(!in_progress, "R3 zero total", in_progress, 0);

    // R6: samples before start are ignored
    load(4);
    feed(6, 0, first);
    chk(first == 0 && !stop_flag, "R6 idle samples", first, 0);
    start();
    feed(4, 0, first);
    chk(first == 4, "R6 full run after idle samples", first, 4);
    clear_flag();

    // R2: load during a run does not alter it; next start uses the new total
    load(5);
    start();
    feed(2, 0, first);
    load(50);
    feed(3, 0, first);
    chk(first == 3, "R2 mid-run load ignored", first, 3);
    clear_flag();
    start();
    feed(50, 0, first);
    chk(first == 50, "R2 new total on restart", first, 50);
    clear_flag();

    // R8: final sample together with clear leaves the flag set
    load(3);
    start();
    feed(2, 0, first);
    sample_stb = 1; stop_clr = 1;
    @(negedge clk); sample_stb = 0; stop_clr = 0;
    chk(done_pulse && stop_flag, "R8 done beats clear", {done_pulse, stop_flag}, 3);
    clear_flag();

    // R9: abort by dropping enable
    load(10);
    start();
    feed(3, 0, first);
    daq_enable = 0;
    @(negedge clk);
    chk(!in_progress && !stop_flag, "R9 aborted", {in_progress, stop_flag}, 0);
    feed(10, 0, first);
    chk(first == 0 && !stop_flag, "R9 no stop after abort", first, 0);

    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule